// File: doc/BRIEF.md
# Bit Test and Bit Scan Unit

This block performs two families of single-word bit operations on a 32-bit operand. The first family tests one selected bit and copies its original value into a carry flag. It can also rewrite that bit: force it high, force it low or flip it. The second family searches the operand for a set bit. It starts either from the least significant end or from the most significant end, and reports the position of the first 1 it meets together with a flag that tells whether the operand held any set bit at all.

A caller presents the operand, a bit selector and a 3-bit operation code, and raises `start` for one cycle. On the next rising edge the unit registers its results and raises `done` for one cycle. An output that the chosen operation does not produce keeps its earlier registered value. Between start pulses every output holds.

Top module: `bit_scan_unit`

## Requirements
- R1: While `rst_n` is low, `result`, `carry`, `scan_idx`, `zflag` and `done` are all 0.
- R2: For operation codes 0 to 3, `carry` takes the value the selected bit of `operand` had before any change.
- R3: Code 0 (test) loads `result` with `operand` unchanged.
- R4: Code 1 loads `result` with `operand` with the selected bit forced to 1. Code 2 loads it with that bit forced to 0. Code 3 loads it with that bit inverted. All other bits are copied unchanged.
- R5: Only the low 5 bits of `bit_sel` select the bit, so the selector is taken modulo 32.
- R6: Code 4 (forward scan) on a non-zero operand loads `scan_idx` with the position of the lowest set bit.
- R7: Code 5 (reverse scan) on a non-zero operand loads `scan_idx` with the position of the highest set bit.
- R8: On codes 4 and 5, `zflag` becomes 1 if `operand` is non-zero and 0 if it is all zeros.
- R9: A scan of an all-zero operand leaves `scan_idx` at its previous registered value.
- R10: `done` is high for exactly the one cycle that follows a cycle with `start` high. Without `start`, no output changes.
- R11: Codes 6 and 7 raise `done` and change no other output.
- R12: Bit-test codes leave `scan_idx` and `zflag` unchanged. Scan codes leave `result` and `carry` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Accept an operation this cycle |
| op | input | 3 | Operation code: 0 test, 1 set, 2 reset, 3 complement, 4 forward scan, 5 reverse scan |
| operand | input | 32 | Source word |
| bit_sel | input | 8 | Bit selector; low 5 bits used |
| result | output | 32 | Word produced by the bit-test operations |
| carry | output | 1 | Original value of the tested bit |
| scan_idx | output | 5 | Position found by the last successful scan |
| zflag | output | 1 | 1 when the last scanned operand was non-zero |
| done | output | 1 | One-cycle completion strobe |

## Verification
Each bit-test code is applied to operands whose selected bit is 1 and to operands whose selected bit is 0. This separates a correct copy into the carry flag from an inverted or constant one, and it shows whether a modify operation touched the right bit. Selectors of 31, 37 and 63 show whether the selector is wrapped to its low 5 bits. The scans use operands that have one set bit, set bits at both ends, and clusters of set bits. On these operands the forward and reverse searches must give different answers, which exposes a swapped or off-by-one search. All-zero operands, reserved codes and idle cycles with changing inputs show whether any output is written when it must hold.

// File: rtl/bit_scan_unit.sv
module bit_scan_unit #(
  parameter int WIDTH = 32,
  parameter int SELW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [2:0]               op,
  input  logic [WIDTH-1:0]         operand,
  input  logic [SELW-1:0]          bit_sel,
  output logic [WIDTH-1:0]         result,
  output logic                     carry,
  output logic [$clog2(WIDTH)-1:0] scan_idx,
  output logic                     zflag,
  output logic                     done
);
  localparam int IDXW = $clog2(WIDTH);
  localparam logic [2:0] OP_TEST = 3'd0;
  localparam logic [2:0] OP_SET  = 3'd1;
  localparam logic [2:0] OP_CLR  = 3'd2;
  localparam logic [2:0] OP_FLIP = 3'd3;
  localparam logic [2:0] OP_FWD  = 3'd4;
  localparam logic [2:0] OP_REV  = 3'd5;

  wire [IDXW-1:0]  pos     = bit_sel[IDXW-1:0];
  wire [WIDTH-1:0] mask    = {{(WIDTH-1){1'b0}}, 1'b1} << pos;
  wire             old_bit = operand[pos];
  wire             is_bit  = (op[2] == 1'b0);
  wire             is_scan = (op == OP_FWD) || (op == OP_REV);
  wire             any_set = |operand;

  logic [WIDTH-1:0] mod_word;
  always_comb begin
    case (op)
      OP_SET:  mod_word = operand | mask;
      OP_CLR:  mod_word = operand & ~mask;
      OP_FLIP: mod_word = operand ^ mask;
      default: mod_word = operand;
    endcase
  end

  logic [IDXW-1:0] lo_idx, hi_idx;
  always_comb begin
    lo_idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--)
      if (operand[i]) lo_idx = i[IDXW-1:0];
  end
  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < WIDTH; i++)
      if (operand[i]) hi_idx = i[IDXW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      carry    <= 1'b0;
      scan_idx <= '0;
      zflag    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= start;
      if (start && is_bit) begin
        result <= mod_word;
        carry  <= old_bit;
      end
      if (start && is_scan) begin
        zflag <= any_set;
        if (any_set) scan_idx <= (op == OP_FWD) ? lo_idx : hi_idx;
      end
    end
  end

  p_done_follows_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  p_test_keeps_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_TEST) |=> result == $past(operand));

  p_zero_scan_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && is_scan && !any_set) |=> ($stable(scan_idx) && !zflag));

  p_fwd_hits_set_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_FWD && any_set) |=> ((($past(operand) >> scan_idx) & WIDTH'(1)) != '0));

  p_rev_is_highest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_REV && any_set) |=> (($past(operand) >> scan_idx) == WIDTH'(1)));

  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(carry) && $stable(scan_idx) && $stable(zflag)));
endmodule

// File: tb/bit_scan_unit_bench.sv
module bit_scan_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] operand = '0;
  logic [7:0]  bit_sel = '0;
  logic [31:0] result;
  logic        carry;
  logic [4:0]  scan_idx;
  logic        zflag;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;

  bit_scan_unit u_bit_scan_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
    .bit_sel(bit_sel), .result(result), .carry(carry), .scan_idx(scan_idx),
    .zflag(zflag), .done(done)
  );

  always #10 clk = ~clk;

  // {op, operand, bit_sel, expected value, expected flag}
  localparam int NV = 12;
  localparam logic [75:0] VEC [NV] = '{
    {3'd0, 32'h0000_0010, 8'd4,  32'h0000_0010, 1'b1},
    {3'd1, 32'h0000_0000, 8'd31, 32'h8000_0000, 1'b0},
    {3'd2, 32'hFFFF_FFFF, 8'd0,  32'hFFFF_FFFE, 1'b1},
    {3'd3, 32'h1234_5678, 8'd3,  32'h1234_5670, 1'b1},
    {3'd1, 32'h0000_0001, 8'd37, 32'h0000_0021, 1'b0},
    {3'd4, 32'h0000_0100, 8'd0,  32'd8,         1'b1},
    {3'd5, 32'h0000_0100, 8'd0,  32'd8,         1'b1},
    {3'd4, 32'h8000_0001, 8'd0,  32'd0,         1'b1},
    {3'd5, 32'h8000_0001, 8'd0,  32'd31,        1'b1},
    {3'd4, 32'hF000_0000, 8'd0,  32'd28,        1'b1},
    {3'd5, 32'h0001_FFFF, 8'd0,  32'd16,        1'b1},
    {3'd3, 32'h8000_0000, 8'd63, 32'h0000_0000, 1'b1}
  };

  logic [31:0] m_res;
  logic        m_cf;
  logic [4:0]  m_idx;
  logic        m_zf;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " result"}, result, m_res);
    chk({req, " carry"}, {31'd0, carry}, {31'd0, m_cf});
    chk({req, " scan_idx"}, {27'd0, scan_idx}, {27'd0, m_idx});
    chk({req, " zflag"}, {31'd0, zflag}, {31'd0, m_zf});
  endtask

  task automatic issue(input logic [2:0] o, input logic [31:0] w, input logic [7:0] s);
    @(negedge clk);
    op = o; operand = w; bit_sel = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_res = '0; m_cf = 1'b0; m_idx = '0; m_zf = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    chk("R1 done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k][75:73], VEC[k][72:41], VEC[k][40:33]);
      chk("R10 done", {31'd0, done}, 32'd1);
      if (VEC[k][75] == 1'b0) begin
        m_res = VEC[k][32:1]; m_cf = VEC[k][0];
        check_all(VEC[k][75:73] == 3'd0 ? "R2 R3 R12" :
                  (VEC[k][40:33] > 8'd31 ? "R2 R4 R5 R12" : "R2 R4 R12"));
      end else begin
        m_idx = VEC[k][5:1]; m_zf = VEC[k][0];
        check_all(VEC[k][75:73] == 3'd4 ? "R6 R8 R12" : "R7 R8 R12");
      end
      @(negedge clk);
      chk("R10 done low", {31'd0, done}, 32'd0);
    end

    issue(3'd4, 32'h0, 8'd0);
    m_zf = 1'b0;
    check_all("R8 R9 fwd zero");
    issue(3'd5, 32'h0, 8'd0);
    check_all("R8 R9 rev zero");

    issue(3'd6, 32'hDEAD_BEEF, 8'd1);
    chk("R11 done", {31'd0, done}, 32'd1);
    check_all("R11 code6");
    issue(3'd7, 32'h0000_0001, 8'd0);
    check_all("R11 code7");

    @(negedge clk);
    op = 3'd1; operand = 32'hFFFF_0000; bit_sel = 8'd2;
    repeat (3) @(negedge clk);
    chk("R10 idle done", {31'd0, done}, 32'd0);
    check_all("R10 idle");

    issue(3'd0, 32'h0000_0000, 8'd15);
    m_res = 32'h0; m_cf = 1'b0;
    check_all("R2 R3 zero bit");

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    m_res = '0; m_cf = 1'b0; m_idx = '0; m_zf = 1'b0;
    check_all("R1 reapply");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule